// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

The block contains two 8-bit up-counting interval timers, a low timer and a high timer. Each has its own compare register, its own tick selector and its own run bit. Each timer advances only on single-cycle tick enables taken from a small bank of prescaler tick inputs. In split operation each timer runs by itself. When a timer reaches its compare value it returns to zero and pulses its own interrupt.

Setting the mode field to cascade joins the two timers into one 16-bit interval timer. The high timer then advances on the low timer's wrap-around, and the two compare registers together form a 16-bit period. Only a match of the full 16-bit value, seen by both comparators in the same cycle, clears the pair, pulses the high interrupt and may toggle the output flip-flop. The low comparator's own matches along the way have no effect.

A write-order rule protects the 16-bit compare. Writing the low compare byte disarms the pair comparison, and writing the high byte arms it again. Software writes the low byte first and the high byte second.

Top module: `cascade_timer`

## Requirements
- R1: While reset is asserted, and after it is released, irq_lo, irq_hi and tmr_out are 0. After reset, all register fields are 0 and the pair comparison is armed.
- R2: Register write port (wr_en, wr_addr, wr_data) and split mode of the low timer.
  - A write takes effect on the clock edge where wr_en is high.
  - Address 0 is the control register:
    - bits 1:0: mode
    - bits 3:2: low tick select
    - bits 5:4: high tick select
    - bit 6: low run
    - bit 7: high run
  - Address 1 is the low compare byte and address 2 is the high compare byte.
  - In split mode (mode other than 01), each tick of the selected input tick_in[low select] advances the low counter while low run is 1.
  - On the tick that would bring the low counter to its compare value C, the counter returns to 0 and irq_lo is high for the following cycle. The period is therefore C ticks, and C = 0 means 256 ticks.
- R3: In split mode the high timer behaves the same way, independently. It uses tick_in[high select], high run, the high compare byte and irq_hi.
- R4: A timer whose run bit is 0 holds its counter at zero and raises no interrupt. Ticks on tick inputs that are not selected have no effect.
- R5: Mode 01 selects cascade. The pair advances on tick_in[low select], and the high counter steps when the low counter wraps from 0xFF, whatever the high tick select holds. With high byte H and low byte L armed, irq_hi pulses on every (H*256+L)-th tick; for example 0x0480 gives 1152 ticks.
- R6: In cascade mode irq_lo never pulses, and a match of the low byte alone does not clear the low counter.
- R7: A write to address 1 disarms the pair comparison and a write to address 2 arms it. While disarmed, the cascaded counter runs past the compare value without an event.
- R8: Output control is written at address 3: bit 0 is invert enable, bit 1 is a load strobe and bit 2 is the load value. On a cascade match, tmr_out toggles in the cycle irq_hi rises if invert enable is 1, and does not change if invert enable is 0.
- R9: In split mode, each high-timer match toggles tmr_out when invert enable is 1.
- R10: A write to address 3 with bit 1 set loads bit 2 into tmr_out on that edge. This load takes priority over a toggle in the same cycle.
- R11: In cascade mode, the low run bit alone starts and stops the pair, and the high run bit is ignored. With low run 0, both counters are held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 low compare, 2 high compare, 3 output control) |
| wr_data | input | 8 | Register write data |
| tick_in | input | 4 | Single-cycle prescaler tick enables |
| irq_lo | output | 1 | Low-timer interrupt pulse (split mode only) |
| irq_hi | output | 1 | High-timer or cascade-match interrupt pulse |
| tmr_out | output | 1 | Timer output flip-flop |

## Verification
The assertions assume the following about the inputs:
- Ticks are one-cycle enables sampled on the system clock.
- At most one register write occurs per cycle.
- A mode change may land with the counters at any value, so no property relates counts across a change of mode.

The stimulus keeps within these limits:
- It drives ticks and writes only between clock edges, one cycle at a time.
- It reprograms the mode freely in the random phase.
- For the long directed cascade periods, it first parks both counters at zero through the run bits.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  localparam int CNT_W  = 8;
  localparam int N_TICK = 4;
  localparam int SEL_W  = $clog2(N_TICK);
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'b00,
    MODE_CASC  = 2'b01,
    MODE_SPL2  = 2'b10,
    MODE_SPL3  = 2'b11
  } mode_e;

  typedef struct packed {
    logic             run_hi;
    logic             run_lo;
    logic [SEL_W-1:0] sel_hi;
    logic [SEL_W-1:0] sel_lo;
    mode_e            mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMPL = 2'd1;
  localparam logic [ADDR_W-1:0] A_CMPH = 2'd2;
  localparam logic [ADDR_W-1:0] A_OUTC = 2'd3;

  localparam int OUT_INV_BIT  = 0;
  localparam int OUT_LOAD_BIT = 1;
  localparam int OUT_VAL_BIT  = 2;

endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output ctrl_t             ctrl,
  output logic [W-1:0]      cmp_lo,
  output logic [W-1:0]      cmp_hi,
  output logic              armed,
  output logic              inv_en,
  output logic              ff_load,
  output logic              ff_load_val
);

  ctrl_t          ctrl_q, ctrl_d;
  logic [W-1:0]   cmpl_q, cmpl_d;
  logic [W-1:0]   cmph_q, cmph_d;
  logic           armed_q, armed_d;
  logic           inv_q, inv_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    cmpl_d  = cmpl_q;
    cmph_d  = cmph_q;
    armed_d = armed_q;
    inv_d   = inv_q;
    if (wr_en) begin
      unique case (wr_addr)
        A_CTRL: ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
        A_CMPL: begin
          cmpl_d  = wr_data;
          armed_d = 1'b0;
        end
        A_CMPH: begin
          cmph_d  = wr_data;
          armed_d = 1'b1;
        end
        A_OUTC: inv_d = wr_data[OUT_INV_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmpl_q  <= '0;
      cmph_q  <= '0;
      armed_q <= 1'b1;
      inv_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      cmpl_q  <= cmpl_d;
      cmph_q  <= cmph_d;
      armed_q <= armed_d;
      inv_q   <= inv_d;
    end
  end

  assign ctrl        = ctrl_q;
  assign cmp_lo      = cmpl_q;
  assign cmp_hi      = cmph_q;
  assign armed       = armed_q;
  assign inv_en      = inv_q;
  assign ff_load     = wr_en && (wr_addr == A_OUTC) && wr_data[OUT_LOAD_BIT];
  assign ff_load_val = wr_data[OUT_VAL_BIT];

  // R7: a low-byte write leaves the pair disarmed
  a_r7_disarm_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CMPL) |=> !armed);

  // R7: a high-byte write re-arms the pair
  a_r7_arm_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CMPH) |=> armed);

endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         step,
  input  logic         clr,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         eq_next
);

  logic [W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (hold || clr) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt     = cnt_q;
  assign eq_next = (cnt_inc == cmp);

  // R4: a stopped timer sits at zero
  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));

  // R4: with neither step nor clear nor hold the count does not move
  a_r4_no_step_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !clr && !step) |=> $stable(cnt));

endmodule

// File: rtl/ctmr_outff.sv
module ctmr_outff (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic toggle,
  output logic q
);

  logic ff_q, ff_d;

  always_comb begin
    ff_d = ff_q;
    if (load) begin
      ff_d = load_val;
    end else if (toggle) begin
      ff_d = ~ff_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
    end else begin
      ff_q <= ff_d;
    end
  end

  assign q = ff_q;

  // R10: a load wins over any toggle in the same cycle
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(load_val)));

  // R8: the output only moves for a load or a toggle request
  a_r8_change_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(load || toggle));

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import ctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [N_TICK-1:0] tick_in,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              tmr_out
);

  localparam int N_TMR = 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = rst_sync_q[1];

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp_lo, cmp_hi;
  logic             armed, inv_en, ff_load, ff_load_val;

  ctmr_regs #(.W(CNT_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ctrl       (ctrl),
    .cmp_lo     (cmp_lo),
    .cmp_hi     (cmp_hi),
    .armed      (armed),
    .inv_en     (inv_en),
    .ff_load    (ff_load),
    .ff_load_val(ff_load_val)
  );

  logic [N_TMR-1:0] hold, step, clr, eq_next;
  logic [CNT_W-1:0] cnt [N_TMR];
  logic [CNT_W-1:0] cmp [N_TMR];

  assign cmp[0] = cmp_lo;
  assign cmp[1] = cmp_hi;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    ctmr_counter #(.W(CNT_W)) cnt_i (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .hold   (hold[g]),
      .step   (step[g]),
      .clr    (clr[g]),
      .cmp    (cmp[g]),
      .cnt    (cnt[g]),
      .eq_next(eq_next[g])
    );
  end

  logic casc;
  logic lo_step, hi_own_step, wrap_lo, hi_eq_now;
  logic pair_match, split_lo_match, split_hi_match;
  logic irq_lo_d, irq_hi_d, toggle;
  logic irq_lo_q, irq_hi_q;

  always_comb begin
    casc        = (ctrl.mode == MODE_CASC);
    lo_step     = ctrl.run_lo & tick_in[ctrl.sel_lo];
    hi_own_step = ctrl.run_hi & tick_in[ctrl.sel_hi];
    wrap_lo     = lo_step & (&cnt[0]);
    hi_eq_now   = (cnt[1] == cmp_hi);

    step[0] = lo_step;
    step[1] = casc ? wrap_lo : hi_own_step;

    // cascade: both byte comparators must agree on the next 16-bit value
    pair_match     = casc & armed & lo_step & eq_next[0] &
                     (wrap_lo ? eq_next[1] : hi_eq_now);
    split_lo_match = ~casc & step[0] & eq_next[0];
    split_hi_match = ~casc & step[1] & eq_next[1];

    clr[0]  = casc ? pair_match : split_lo_match;
    clr[1]  = casc ? pair_match : split_hi_match;
    hold[0] = ~ctrl.run_lo;
    hold[1] = casc ? ~ctrl.run_lo : ~ctrl.run_hi;

    irq_lo_d = split_lo_match;
    irq_hi_d = pair_match | split_hi_match;
    toggle   = inv_en & irq_hi_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      irq_lo_q <= irq_lo_d;
      irq_hi_q <= irq_hi_d;
    end
  end

  ctmr_outff outff_i (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load    (ff_load),
    .load_val(ff_load_val),
    .toggle  (toggle),
    .q       (tmr_out)
  );

  assign irq_lo = irq_lo_q;
  assign irq_hi = irq_hi_q;

  // R6: no low interrupt while cascaded
  a_r6_no_low_irq_cascade: assert property (@(posedge clk) disable iff (!rst_s_n)
    casc |=> !irq_lo);

  // R8: a 16-bit match clears the pair and raises the high interrupt
  a_r8_pair_clears: assert property (@(posedge clk) disable iff (!rst_s_n)
    pair_match |=> (cnt[0] == '0 && cnt[1] == '0 && irq_hi));

  // R7: a disarmed pair produces no high interrupt
  a_r7_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    (casc && !armed) |=> !irq_hi);

  // R5: the high byte moves only on the low byte's wrap in cascade
  a_r5_high_follows_wrap: assert property (@(posedge clk) disable iff (!rst_s_n)
    (casc && ctrl.run_lo && !wrap_lo && !pair_match) |=> $stable(cnt[1]));

endmodule

// File: tb/cascade_timer_tb_top.sv
`timescale 1ns/1ps
module cascade_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] tick_in;
  logic       irq_lo, irq_hi, tmr_out;

  always #10 clk = ~clk;

  cascade_timer dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .tick_in(tick_in),
    .irq_lo (irq_lo),
    .irq_hi (irq_hi),
    .tmr_out(tmr_out)
  );

  int total = 0;
  int bad   = 0;
  int n_lo  = 0;
  int n_hi  = 0;

  // reference model state
  int m_lo, m_hi, m_mode, m_sel_lo, m_sel_hi, m_run_lo, m_run_hi;
  int m_cmpl, m_cmph, m_armed, m_inv, m_ff;
  int e_lo, e_hi;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_init();
    m_lo = 0; m_hi = 0; m_mode = 0; m_sel_lo = 0; m_sel_hi = 0;
    m_run_lo = 0; m_run_hi = 0; m_cmpl = 0; m_cmph = 0;
    m_armed = 1; m_inv = 0; m_ff = 0; e_lo = 0; e_hi = 0;
  endtask

  task automatic model_step(input logic [3:0] tk, input logic we,
                            input logic [1:0] a, input logic [7:0] d);
    int n;
    int tog;
    tog  = 0;
    e_lo = 0;
    e_hi = 0;
    if (m_mode == 1) begin
      if (m_run_lo == 0) begin
        m_lo = 0; m_hi = 0;
      end else if (tk[m_sel_lo]) begin
        n = (((m_hi << 8) | m_lo) + 1) & 16'hFFFF;
        if (m_armed != 0 && n == ((m_cmph << 8) | m_cmpl)) begin
          m_lo = 0; m_hi = 0; e_hi = 1; tog = m_inv;
        end else begin
          m_lo = n & 255; m_hi = n >> 8;
        end
      end
    end else begin
      if (m_run_lo == 0) m_lo = 0;
      else if (tk[m_sel_lo]) begin
        n = (m_lo + 1) & 255;
        if (n == m_cmpl) begin m_lo = 0; e_lo = 1; end
        else m_lo = n;
      end
      if (m_run_hi == 0) m_hi = 0;
      else if (tk[m_sel_hi]) begin
        n = (m_hi + 1) & 255;
        if (n == m_cmph) begin m_hi = 0; e_hi = 1; tog = m_inv; end
        else m_hi = n;
      end
    end
    if (we && a == 2'd3 && d[1]) m_ff = d[2];
    else if (tog != 0) m_ff = 1 - m_ff;
    if (we) begin
      case (a)
        2'd0: begin
          m_mode = d[1:0]; m_sel_lo = d[3:2]; m_sel_hi = d[5:4];
          m_run_lo = d[6]; m_run_hi = d[7];
        end
        2'd1: begin m_cmpl = d; m_armed = 0; end
        2'd2: begin m_cmph = d; m_armed = 1; end
        default: m_inv = d[0];
      endcase
    end
  endtask

  task automatic cyc(input logic [3:0] tk, input logic we, input logic [1:0] a,
                     input logic [7:0] d, input string tag);
    tick_in = tk; wr_en = we; wr_addr = a; wr_data = d;
    model_step(tk, we, a, d);
    @(posedge clk);
    @(negedge clk);
    tick_in = '0; wr_en = 1'b0;
    chk(tag, "irq_lo", int'(irq_lo), e_lo);
    chk(tag, "irq_hi", int'(irq_hi), e_hi);
    chk(tag, "tmr_out", int'(tmr_out), m_ff);
    if (irq_lo) n_lo++;
    if (irq_hi) n_hi++;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    cyc(4'b0000, 1'b1, a, d, tag);
  endtask

  task automatic ticks(input int n, input logic [3:0] tk, input string tag);
    for (int i = 0; i < n; i++) cyc(tk, 1'b0, 2'd0, 8'd0, tag);
  endtask

  initial begin
    #(20ns * 190000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s_lo, s_hi;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; tick_in = '0;
    model_init();
    repeat (3) @(negedge clk);
    chk("R1", "irq_lo in reset", int'(irq_lo), 0);
    chk("R1", "irq_hi in reset", int'(irq_hi), 0);
    chk("R1", "tmr_out in reset", int'(tmr_out), 0);
    rst_n = 1'b1;
    ticks(3, 4'b0000, "R1");

    // R2: low timer split, tick line 1, period 5
    wr(2'd0, 8'h44, "R2");
    wr(2'd1, 8'd5, "R2");
    s_lo = n_lo;
    ticks(30, 4'b0010, "R2");
    chk("R2", "low irq count over 30 ticks", n_lo - s_lo, 6);
    // R4: unselected lines do nothing
    s_lo = n_lo;
    ticks(10, 4'b1101, "R4");
    chk("R4", "low irq on unselected ticks", n_lo - s_lo, 0);

    // R3: high timer split on line 2, period 3
    wr(2'd0, 8'hE4, "R3");
    wr(2'd2, 8'd3, "R3");
    s_lo = n_lo; s_hi = n_hi;
    ticks(12, 4'b0100, "R3");
    chk("R3", "high irq count over 12 ticks", n_hi - s_hi, 4);
    chk("R3", "low irq while only high ticks", n_lo - s_lo, 0);

    // R4: run bits cleared hold both at zero
    wr(2'd0, 8'h24, "R4");
    s_lo = n_lo; s_hi = n_hi;
    ticks(20, 4'b1111, "R4");
    chk("R4", "no irq while stopped", (n_lo - s_lo) + (n_hi - s_hi), 0);
    wr(2'd0, 8'h64, "R4");
    s_lo = n_lo;
    ticks(4, 4'b0010, "R4");
    chk("R4", "restart from zero, 4 ticks", n_lo - s_lo, 0);
    ticks(1, 4'b0010, "R4");
    chk("R4", "restart from zero, 5th tick", n_lo - s_lo, 1);

    // R5 R6 R11: cascade 0x0480, high run off, high select on line 3
    wr(2'd0, 8'h00, "R5");
    wr(2'd0, 8'h71, "R5");
    wr(2'd1, 8'h80, "R5");
    wr(2'd2, 8'h04, "R5");
    s_lo = n_lo; s_hi = n_hi;
    for (int i = 0; i < 1151; i++)
      cyc({1'($urandom_range(1)), 3'b001}, 1'b0, 2'd0, 8'd0, "R5");
    chk("R5", "no pair event before 0x480 ticks", n_hi - s_hi, 0);
    ticks(1, 4'b0001, "R5");
    chk("R11", "pair event at tick 0x480 with high run off", n_hi - s_hi, 1);
    ticks(1152, 4'b0001, "R5");
    chk("R5", "second pair event one period later", n_hi - s_hi, 2);
    chk("R6", "no low irq in cascade", n_lo - s_lo, 0);
    chk("R8", "no toggle with invert off", int'(tmr_out), 0);

    // R8: invert enabled toggles on the pair event
    wr(2'd3, 8'h01, "R8");
    ticks(1152, 4'b0001, "R8");
    chk("R8", "tmr_out toggled by pair event", int'(tmr_out), 1);

    // R7: disarmed runs past the compare value
    wr(2'd1, 8'h80, "R7");
    s_hi = n_hi;
    ticks(1200, 4'b0001, "R7");
    chk("R7", "no event while disarmed", n_hi - s_hi, 0);
    wr(2'd1, 8'hC0, "R7");
    wr(2'd2, 8'h04, "R7");
    ticks(15, 4'b0001, "R7");
    chk("R7", "armed, 15 ticks short of 0x4C0", n_hi - s_hi, 0);
    ticks(1, 4'b0001, "R7");
    chk("R7", "armed, event at 0x4C0", n_hi - s_hi, 1);

    // R11: high run alone does not start the cascaded pair
    wr(2'd0, 8'hB1, "R11");
    wr(2'd1, 8'h02, "R11");
    wr(2'd2, 8'h00, "R11");
    s_hi = n_hi;
    ticks(20, 4'b1111, "R11");
    chk("R11", "pair held with low run off", n_hi - s_hi, 0);
    wr(2'd0, 8'h71, "R11");
    ticks(2, 4'b0001, "R11");
    chk("R11", "pair runs with low run on", n_hi - s_hi, 1);

    // R9 R10: split high timer with period 1 toggles every tick
    wr(2'd0, 8'h00, "R9");
    wr(2'd0, 8'hA0, "R9");
    wr(2'd2, 8'h01, "R9");
    wr(2'd3, 8'h03, "R10");
    chk("R10", "load 0", int'(tmr_out), 0);
    ticks(1, 4'b0100, "R9");
    chk("R9", "toggle to 1", int'(tmr_out), 1);
    ticks(1, 4'b0100, "R9");
    chk("R9", "toggle to 0", int'(tmr_out), 0);
    cyc(4'b0100, 1'b1, 2'd3, 8'h03, "R10");
    chk("R10", "load 0 beats toggle", int'(tmr_out), 0);
    cyc(4'b0100, 1'b1, 2'd3, 8'h07, "R10");
    chk("R10", "load 1 beats toggle", int'(tmr_out), 1);

    // random phase checked against the model
    for (int i = 0; i < 20000; i++) begin
      logic [3:0] tk;
      logic [1:0] a;
      logic [7:0] d;
      tk = 4'($urandom);
      a  = 2'($urandom);
      d  = 8'($urandom);
      if (a == 2'd1 || a == 2'd2) d = d & 8'h07;
      if ($urandom_range(15) == 0)
        cyc(tk, 1'b1, a, d, (m_mode == 1) ? "R5" : "R2");
      else
        cyc(tk, 1'b0, 2'd0, 8'd0, (m_mode == 1) ? "R5" : "R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule